// File: doc/BRIEF.md
# Store-Load Pair Dependence Predictor

This block tells each load whether it has to search the store queue or can take its data straight from the cache. It holds two tables. A set-ID table is indexed by a hash of an instruction's program counter and maps load and store PCs to a shared set identifier. A set table is indexed by that identifier. Each set entry keeps a pending bit and a small occupancy counter. The pending bit covers the fetch-to-issue window and drives store-set style waiting. The counter covers the fetch-to-commit window and drives the search decision.

Stores report four events on separate ports: fetch, issue, commit and squash. A load looks up its PC combinationally and gets two answers. One says whether a store queue search is needed. The other says whether an older store of its set is still unissued. A training port pairs any load and store found to match on address, whether or not the pair caused an ordering violation.

Top module: `sldp_top`

## Requirements
- R1: The set-ID table index is the XOR-fold of every PC bit, where bit b goes to index bit (b mod index width). A load whose PC has no valid entry reads as independent, with ld_search=0 and ld_wait=0.
- R2: A store fetch that hits a valid ID sets that set's pending bit and raises its counter by one.
- R3: A store issue clears its set's pending bit and leaves the counter unchanged.
- R4: A store commit lowers its set's counter by one.
- R5: ld_search is 1 exactly when ld_vld is high, the load's ID is valid and its set counter is nonzero. ld_wait is 1 exactly when ld_vld is high, the ID is valid and the pending bit is set.
- R6: A store squash lowers its set's counter by one, one cycle later than a commit would. The counter first changes at the second rising edge after the squash is presented.
- R7: The counter is 3 bits wide by default. It saturates at 7 on increment and at 0 on decrement. cnt_sat is high for the one cycle that follows any clamping edge.
- R8: An increment and a decrement that reach the same set at the same edge leave its counter unchanged. A fetch and an issue that reach the same set at the same edge leave the pending bit set.
- R9: Training behaves as follows. If neither PC has an ID, both get the next ID from a rotating allocator that starts at 0. If only one PC has an ID, the other adopts it. If both have IDs and they differ, both take the smaller one. Table writes from training and store events are visible from the next edge on.
- R10: After reset every ID entry is invalid, every set has a counter of 0 and a clear pending bit, cnt_sat is 0, and the allocator is at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_fetch_vld | input | 1 | A store is fetched |
| st_fetch_pc | input | PC_W | PC of the fetched store |
| st_issue_vld | input | 1 | A store issues |
| st_issue_pc | input | PC_W | PC of the issuing store |
| st_commit_vld | input | 1 | A store commits |
| st_commit_pc | input | PC_W | PC of the committing store |
| st_squash_vld | input | 1 | An in-flight store is squashed |
| st_squash_pc | input | PC_W | PC of the squashed store |
| ld_vld | input | 1 | Load lookup request |
| ld_pc | input | PC_W | PC of the load |
| ld_search | output | 1 | Load must search the store queue |
| ld_wait | output | 1 | An unissued store of the load's set exists |
| trn_vld | input | 1 | Record a matching load-store pair |
| trn_ld_pc | input | PC_W | PC of the trained load |
| trn_st_pc | input | PC_W | PC of the trained store |
| cnt_sat | output | 1 | A counter update was clamped on the previous edge |

## Verification
Two pairs of functions can land on the same set counter at the same edge. The first pair is a fetch and a commit, which the bench drives together in one cycle and expects to leave the count unchanged. The second pair is a squash's delayed decrement and a commit: the bench presents a squash and, in the next cycle, a commit to the same set, and expects a count of 2 to drop to 0 at that single edge. The bench judges both cases through ld_search and ld_wait of a load trained into the set. The checker also compares the counter across each edge in which only one event reaches it.

// File: rtl/sldp_pkg.sv
package sldp_pkg;

    // How a training request resolves the two set IDs
    typedef enum logic [1:0] {
        TRN_ALLOC    = 2'd0,  // neither PC known: fresh ID to both
        TRN_ST_TAKES = 2'd1,  // only the load known: store adopts
        TRN_LD_TAKES = 2'd2,  // only the store known: load adopts
        TRN_MERGE    = 2'd3   // both known: both take the smaller ID
    } trn_kind_e;

    function automatic trn_kind_e trn_classify(input logic ld_known, input logic st_known);
        case ({ld_known, st_known})
            2'b00:   return TRN_ALLOC;
            2'b10:   return TRN_ST_TAKES;
            2'b01:   return TRN_LD_TAKES;
            default: return TRN_MERGE;
        endcase
    endfunction

    function automatic int clamp_range(input int val, input int maxv);
        if (val > maxv) return maxv;
        if (val < 0)    return 0;
        return val;
    endfunction

endpackage

// File: rtl/sldp_id_table.sv
module sldp_id_table #(
    parameter int PC_W    = 32,
    parameter int ENTRIES = 256,
    parameter int SID_W   = 4,
    parameter int NRD     = 7,
    parameter int NWR     = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PC_W-1:0]  rd_pc  [NRD],
    output logic [NRD-1:0]   rd_hit,
    output logic [SID_W-1:0] rd_sid [NRD],
    input  logic [NWR-1:0]   wr_en,
    input  logic [PC_W-1:0]  wr_pc  [NWR],
    input  logic [SID_W-1:0] wr_sid [NWR]
);
    localparam int IDX_W = $clog2(ENTRIES);

    function automatic logic [IDX_W-1:0] fold(input logic [PC_W-1:0] pc);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int b = 0; b < PC_W; b++) r[b % IDX_W] ^= pc[b];
        return r;
    endfunction

    logic [ENTRIES-1:0] ent_vld;
    logic [SID_W-1:0]   ent_sid [ENTRIES];

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_hit[p] = ent_vld[fold(rd_pc[p])];
        assign rd_sid[p] = ent_sid[fold(rd_pc[p])];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_vld <= '0;
        end else begin
            for (int w = 0; w < NWR; w++) begin
                if (wr_en[w]) ent_vld[fold(wr_pc[w])] <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int w = 0; w < NWR; w++) begin
            if (wr_en[w]) ent_sid[fold(wr_pc[w])] <= wr_sid[w];
        end
    end

endmodule

// File: rtl/sldp_set_table.sv
module sldp_set_table #(
    parameter int NSET  = 16,
    parameter int CNT_W = 3,
    parameter int NDEC  = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    inc_en,
    input  logic [$clog2(NSET)-1:0] inc_sid,
    input  logic                    iss_en,
    input  logic [$clog2(NSET)-1:0] iss_sid,
    input  logic [NDEC-1:0]         dec_en,
    input  logic [$clog2(NSET)-1:0] dec_sid [NDEC],
    output logic [NSET-1:0]         pend,
    output logic [NSET*CNT_W-1:0]   cnt_flat,
    output logic                    sat
);
    localparam int MAXC = (1 << CNT_W) - 1;

    logic [NSET-1:0] clamp;

    for (genvar i = 0; i < NSET; i++) begin : g_set
        logic [CNT_W-1:0] cnt_q, cnt_d;
        logic             hit_inc, hit_iss;
        int               ndec, nx;

        assign hit_inc = inc_en && (int'(inc_sid) == i);
        assign hit_iss = iss_en && (int'(iss_sid) == i);

        always_comb begin
            ndec = 0;
            for (int d = 0; d < NDEC; d++) begin
                if (dec_en[d] && (int'(dec_sid[d]) == i)) ndec = ndec + 1;
            end
            nx       = int'(cnt_q) + (hit_inc ? 1 : 0) - ndec;
            cnt_d    = CNT_W'(sldp_pkg::clamp_range(nx, MAXC));
            clamp[i] = (nx > MAXC) || (nx < 0);
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q   <= '0;
                pend[i] <= 1'b0;
            end else begin
                cnt_q <= cnt_d;
                if (hit_inc)      pend[i] <= 1'b1;
                else if (hit_iss) pend[i] <= 1'b0;
            end
        end

        assign cnt_flat[i*CNT_W +: CNT_W] = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) sat <= 1'b0;
        else     sat <= |clamp;
    end

endmodule

// File: rtl/sldp_trainer.sv
module sldp_trainer #(
    parameter int PC_W = 32,
    parameter int NSET = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    trn_vld,
    input  logic [PC_W-1:0]         ld_pc,
    input  logic [PC_W-1:0]         st_pc,
    input  logic                    ld_hit,
    input  logic [$clog2(NSET)-1:0] ld_sid,
    input  logic                    st_hit,
    input  logic [$clog2(NSET)-1:0] st_sid,
    output logic [1:0]              wr_en,
    output logic [PC_W-1:0]         wr_pc  [2],
    output logic [$clog2(NSET)-1:0] wr_sid [2]
);
    import sldp_pkg::*;
    localparam int SID_W = $clog2(NSET);

    logic [SID_W-1:0] alloc_q;
    logic [SID_W-1:0] low_sid;
    trn_kind_e        kind;

    assign kind    = trn_classify(ld_hit, st_hit);
    assign low_sid = (ld_sid < st_sid) ? ld_sid : st_sid;
    assign wr_pc[0] = ld_pc;
    assign wr_pc[1] = st_pc;

    always_comb begin
        wr_en     = 2'b00;
        wr_sid[0] = low_sid;
        wr_sid[1] = low_sid;
        if (trn_vld) begin
            unique case (kind)
                TRN_ALLOC: begin
                    wr_en     = 2'b11;
                    wr_sid[0] = alloc_q;
                    wr_sid[1] = alloc_q;
                end
                TRN_ST_TAKES: begin
                    wr_en     = 2'b10;
                    wr_sid[1] = ld_sid;
                end
                TRN_LD_TAKES: begin
                    wr_en     = 2'b01;
                    wr_sid[0] = st_sid;
                end
                TRN_MERGE: begin
                    wr_en = (ld_sid != st_sid) ? 2'b11 : 2'b00;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            alloc_q <= '0;
        end else if (trn_vld && kind == TRN_ALLOC) begin
            alloc_q <= (int'(alloc_q) == NSET - 1) ? '0 : alloc_q + 1'b1;
        end
    end

endmodule

// File: rtl/sldp_top.sv
module sldp_top #(
    parameter int PC_W       = 32,
    parameter int ID_ENTRIES = 256,
    parameter int NSET       = 16,
    parameter int CNT_W      = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            st_fetch_vld,
    input  logic [PC_W-1:0] st_fetch_pc,
    input  logic            st_issue_vld,
    input  logic [PC_W-1:0] st_issue_pc,
    input  logic            st_commit_vld,
    input  logic [PC_W-1:0] st_commit_pc,
    input  logic            st_squash_vld,
    input  logic [PC_W-1:0] st_squash_pc,
    input  logic            ld_vld,
    input  logic [PC_W-1:0] ld_pc,
    output logic            ld_search,
    output logic            ld_wait,
    input  logic            trn_vld,
    input  logic [PC_W-1:0] trn_ld_pc,
    input  logic [PC_W-1:0] trn_st_pc,
    output logic            cnt_sat
);
    localparam int SID_W = $clog2(NSET);
    localparam int NRD   = 7;
    localparam int P_FET = 0, P_ISS = 1, P_CMT = 2, P_SQ = 3, P_LD = 4, P_TL = 5, P_TS = 6;

    logic [PC_W-1:0]  rd_pc  [NRD];
    logic [NRD-1:0]   rd_hit;
    logic [SID_W-1:0] rd_sid [NRD];
    logic [1:0]       wr_en;
    logic [PC_W-1:0]  wr_pc  [2];
    logic [SID_W-1:0] wr_sid [2];

    assign rd_pc[P_FET] = st_fetch_pc;
    assign rd_pc[P_ISS] = st_issue_pc;
    assign rd_pc[P_CMT] = st_commit_pc;
    assign rd_pc[P_SQ]  = st_squash_pc;
    assign rd_pc[P_LD]  = ld_pc;
    assign rd_pc[P_TL]  = trn_ld_pc;
    assign rd_pc[P_TS]  = trn_st_pc;

    sldp_id_table #(
        .PC_W(PC_W), .ENTRIES(ID_ENTRIES), .SID_W(SID_W), .NRD(NRD), .NWR(2)
    ) u_ids (
        .clk(clk), .rst(rst),
        .rd_pc(rd_pc), .rd_hit(rd_hit), .rd_sid(rd_sid),
        .wr_en(wr_en), .wr_pc(wr_pc), .wr_sid(wr_sid)
    );

    sldp_trainer #(.PC_W(PC_W), .NSET(NSET)) u_trn (
        .clk(clk), .rst(rst), .trn_vld(trn_vld),
        .ld_pc(trn_ld_pc), .st_pc(trn_st_pc),
        .ld_hit(rd_hit[P_TL]), .ld_sid(rd_sid[P_TL]),
        .st_hit(rd_hit[P_TS]), .st_sid(rd_sid[P_TS]),
        .wr_en(wr_en), .wr_pc(wr_pc), .wr_sid(wr_sid)
    );

    // Store events that resolve to a known set
    logic fetch_hit, iss_hit, cmt_hit;
    assign fetch_hit = st_fetch_vld  && rd_hit[P_FET];
    assign iss_hit   = st_issue_vld  && rd_hit[P_ISS];
    assign cmt_hit   = st_commit_vld && rd_hit[P_CMT];

    // Squash rollback takes one recovery cycle before reaching the counter
    logic             sq_app;
    logic [SID_W-1:0] sq_sid;
    always_ff @(posedge clk) begin
        if (rst) begin
            sq_app <= 1'b0;
            sq_sid <= '0;
        end else begin
            sq_app <= st_squash_vld && rd_hit[P_SQ];
            sq_sid <= rd_sid[P_SQ];
        end
    end

    logic [SID_W-1:0]      dec_sid [2];
    logic [NSET-1:0]       set_pend;
    logic [NSET*CNT_W-1:0] set_cnt;

    assign dec_sid[0] = rd_sid[P_CMT];
    assign dec_sid[1] = sq_sid;

    sldp_set_table #(.NSET(NSET), .CNT_W(CNT_W), .NDEC(2)) u_sets (
        .clk(clk), .rst(rst),
        .inc_en(fetch_hit), .inc_sid(rd_sid[P_FET]),
        .iss_en(iss_hit),   .iss_sid(rd_sid[P_ISS]),
        .dec_en({sq_app, cmt_hit}), .dec_sid(dec_sid),
        .pend(set_pend), .cnt_flat(set_cnt), .sat(cnt_sat)
    );

    logic ld_known;
    assign ld_known  = ld_vld && rd_hit[P_LD];
    assign ld_search = ld_known && (set_cnt[rd_sid[P_LD]*CNT_W +: CNT_W] != '0);
    assign ld_wait   = ld_known && set_pend[rd_sid[P_LD]];

endmodule

// File: rtl/sldp_chk.sv
module sldp_chk #(
    parameter int NSET  = 16,
    parameter int CNT_W = 3,
    parameter int SID_W = 4
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  fetch_hit,
    input logic [SID_W-1:0]      fetch_sid,
    input logic                  iss_hit,
    input logic [SID_W-1:0]      iss_sid,
    input logic                  cmt_hit,
    input logic [SID_W-1:0]      cmt_sid,
    input logic                  sq_app,
    input logic [SID_W-1:0]      sq_sid,
    input logic [NSET-1:0]       set_pend,
    input logic [NSET*CNT_W-1:0] set_cnt,
    input logic                  cnt_sat
);
    localparam logic [CNT_W-1:0] MAXC = '1;

    function automatic logic [CNT_W-1:0] cnt_of(input logic [SID_W-1:0] s);
        return set_cnt[s*CNT_W +: CNT_W];
    endfunction

    logic f_alone, c_alone, s_alone;
    assign f_alone = fetch_hit && !(cmt_hit && cmt_sid == fetch_sid) && !(sq_app && sq_sid == fetch_sid);
    assign c_alone = cmt_hit && !(fetch_hit && fetch_sid == cmt_sid) && !(sq_app && sq_sid == cmt_sid);
    assign s_alone = sq_app && !(fetch_hit && fetch_sid == sq_sid) && !(cmt_hit && cmt_sid == sq_sid);

    a_r2_fetch_sets_pending: assert property (@(posedge clk) disable iff (rst)
        fetch_hit |=> set_pend[$past(fetch_sid)]);

    a_r2_fetch_counts_up: assert property (@(posedge clk) disable iff (rst)
        f_alone && cnt_of(fetch_sid) != MAXC
        |=> cnt_of($past(fetch_sid)) == CNT_W'($past(cnt_of(fetch_sid)) + 1'b1));

    a_r3_issue_clears_pending: assert property (@(posedge clk) disable iff (rst)
        iss_hit && !(fetch_hit && fetch_sid == iss_sid) |=> !set_pend[$past(iss_sid)]);

    a_r4_commit_counts_down: assert property (@(posedge clk) disable iff (rst)
        c_alone && cnt_of(cmt_sid) != '0
        |=> cnt_of($past(cmt_sid)) == CNT_W'($past(cnt_of(cmt_sid)) - 1'b1));

    a_r6_squash_counts_down: assert property (@(posedge clk) disable iff (rst)
        s_alone && cnt_of(sq_sid) != '0
        |=> cnt_of($past(sq_sid)) == CNT_W'($past(cnt_of(sq_sid)) - 1'b1));

    a_r7_sat_on_overflow: assert property (@(posedge clk) disable iff (rst)
        f_alone && cnt_of(fetch_sid) == MAXC |=> cnt_sat && cnt_of($past(fetch_sid)) == MAXC);

endmodule

bind sldp_top sldp_chk #(.NSET(NSET), .CNT_W(CNT_W), .SID_W(SID_W)) u_chk (
    .clk(clk), .rst(rst),
    .fetch_hit(fetch_hit), .fetch_sid(rd_sid[P_FET]),
    .iss_hit(iss_hit),     .iss_sid(rd_sid[P_ISS]),
    .cmt_hit(cmt_hit),     .cmt_sid(rd_sid[P_CMT]),
    .sq_app(sq_app),       .sq_sid(sq_sid),
    .set_pend(set_pend),   .set_cnt(set_cnt),
    .cnt_sat(cnt_sat)
);

// File: tb/sldp_top_tb.sv
module sldp_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        st_fetch_vld = 0, st_issue_vld = 0, st_commit_vld = 0, st_squash_vld = 0;
    logic [31:0] st_fetch_pc = 0, st_issue_pc = 0, st_commit_pc = 0, st_squash_pc = 0;
    logic        ld_vld = 0;
    logic [31:0] ld_pc = 0;
    logic        trn_vld = 0;
    logic [31:0] trn_ld_pc = 0, trn_st_pc = 0;
    logic        ld_search, ld_wait, cnt_sat;

    int runs = 0;
    int fails = 0;

    always #5 clk = ~clk;

    sldp_top u_dut (
        .clk(clk), .rst(rst),
        .st_fetch_vld(st_fetch_vld), .st_fetch_pc(st_fetch_pc),
        .st_issue_vld(st_issue_vld), .st_issue_pc(st_issue_pc),
        .st_commit_vld(st_commit_vld), .st_commit_pc(st_commit_pc),
        .st_squash_vld(st_squash_vld), .st_squash_pc(st_squash_pc),
        .ld_vld(ld_vld), .ld_pc(ld_pc),
        .ld_search(ld_search), .ld_wait(ld_wait),
        .trn_vld(trn_vld), .trn_ld_pc(trn_ld_pc), .trn_st_pc(trn_st_pc),
        .cnt_sat(cnt_sat)
    );

    // PCs chosen so their folded indices (1,2,3,4,5,6,9,14) do not alias
    localparam logic [31:0] L0 = 32'h100, S0 = 32'h200, L1 = 32'h104, S2 = 32'h204;
    localparam logic [31:0] L2 = 32'h108, S3 = 32'h20C, L4 = 32'h300, S4 = 32'h400;

    // {fetch, issue, commit, squash, exp_search, exp_wait} on store S0, load L0
    localparam int NV = 12;
    localparam logic [5:0] VEC [NV] = '{
        6'b1000_11, // R2 fetch: cnt1 pending
        6'b0100_10, // R3 issue: cnt1 not pending
        6'b0010_00, // R4 commit: cnt0
        6'b1000_11, // R2 cnt1
        6'b1000_11, // R2 cnt2
        6'b0010_11, // R4 cnt1
        6'b1010_11, // R8 fetch+commit: cnt1
        6'b0001_01, // R6 squash: cnt0, still pending
        6'b0100_00, // R3 issue: idle
        6'b1100_11, // R8 fetch+issue: cnt1 pending
        6'b0010_01, // R4 commit: cnt0
        6'b0100_00  // R3 issue
    };

    task automatic check(input string req, input string what, input logic act, input logic exp);
        runs++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic look(input string req, input logic [31:0] pc, input logic es, input logic ew);
        ld_vld = 1'b1;
        ld_pc  = pc;
        #1;
        check(req, "ld_search", ld_search, es);
        check(req, "ld_wait", ld_wait, ew);
    endtask

    // Present store events for one cycle; returns at the following falling edge
    task automatic pulse(input logic f, input logic i, input logic c, input logic s, input logic [31:0] pc);
        st_fetch_vld = f;  st_fetch_pc  = pc;
        st_issue_vld = i;  st_issue_pc  = pc;
        st_commit_vld = c; st_commit_pc = pc;
        st_squash_vld = s; st_squash_pc = pc;
        @(negedge clk);
        st_fetch_vld = 0; st_issue_vld = 0; st_commit_vld = 0; st_squash_vld = 0;
    endtask

    task automatic train(input logic [31:0] lp, input logic [31:0] sp);
        trn_vld = 1'b1; trn_ld_pc = lp; trn_st_pc = sp;
        @(negedge clk);
        trn_vld = 1'b0;
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        check("R10", "cnt_sat", cnt_sat, 1'b0);
        look("R10", L0, 1'b0, 1'b0);

        train(L0, S0);                        // R9 alloc: both get ID 0
        for (int v = 0; v < NV; v++) begin
            pulse(VEC[v][5], VEC[v][4], VEC[v][3], VEC[v][2], S0);
            @(negedge clk);
            look($sformatf("R5 vec%0d", v), L0, VEC[v][1], VEC[v][0]);
        end

        // R1 untrained load stays independent while set 0 is busy
        pulse(1, 0, 0, 0, S0);
        look("R1", L1, 1'b0, 1'b0);
        look("R5", L0, 1'b1, 1'b1);
        // R9 load adopts the store's ID
        train(L1, S0);
        look("R9 adopt", L1, 1'b1, 1'b1);
        // R9 store adopts the load's ID
        train(L0, S3);
        pulse(0, 0, 1, 0, S0);
        look("R4", L0, 1'b0, 1'b1);
        pulse(1, 0, 0, 0, S3);
        look("R9 st-adopt", L0, 1'b1, 1'b1);
        pulse(0, 1, 1, 0, S3);
        look("R4", L0, 1'b0, 1'b0);
        // R9 fresh allocation gives ID 1, independent of set 0
        train(L2, S2);
        pulse(1, 0, 0, 0, S2);
        look("R9 alloc", L2, 1'b1, 1'b1);
        look("R9 separate", L0, 1'b0, 1'b0);
        pulse(0, 1, 1, 0, S2);
        // R9 merge: L2 (ID 1) with S0 (ID 0) -> both ID 0
        train(L2, S0);
        pulse(1, 0, 0, 0, S0);
        look("R9 merge", L2, 1'b1, 1'b1);
        pulse(0, 1, 1, 0, S0);
        pulse(1, 0, 0, 0, S2);
        look("R9 merge", L2, 1'b0, 1'b0);
        pulse(0, 1, 1, 0, S2);

        // R6 squash takes effect one cycle after a commit would
        pulse(1, 0, 0, 0, S0);
        pulse(0, 0, 0, 1, S0);
        look("R6 delayed", L0, 1'b1, 1'b1);
        @(negedge clk);
        look("R6 applied", L0, 1'b0, 1'b1);
        // R8 squash rollback and commit land on the same edge: 2 -> 0
        pulse(1, 0, 0, 0, S0);
        pulse(1, 0, 0, 0, S0);
        pulse(0, 0, 0, 1, S0);
        pulse(0, 0, 1, 0, S0);
        look("R8 double dec", L0, 1'b0, 1'b1);
        pulse(0, 1, 0, 0, S0);

        // R7 saturation on a fresh set (ID 2)
        train(L4, S4);
        for (int k = 0; k < 7; k++) begin
            pulse(1, 0, 0, 0, S4);
            check("R7 no sat below max", "cnt_sat", cnt_sat, 1'b0);
        end
        pulse(1, 0, 0, 0, S4);
        check("R7 sat at 8th fetch", "cnt_sat", cnt_sat, 1'b1);
        @(negedge clk);
        check("R7 sat one cycle", "cnt_sat", cnt_sat, 1'b0);
        for (int k = 0; k < 6; k++) pulse(0, 0, 1, 0, S4);
        look("R7 held at 7", L4, 1'b1, 1'b1);
        pulse(0, 1, 1, 0, S4);
        check("R7 no sat at 1->0", "cnt_sat", cnt_sat, 1'b0);
        look("R7 reached 0", L4, 1'b0, 1'b0);
        pulse(0, 0, 1, 0, S4);
        check("R7 sat at underflow", "cnt_sat", cnt_sat, 1'b1);
        look("R7 floor 0", L4, 1'b0, 1'b0);
        pulse(1, 0, 0, 0, S4);
        look("R7 from 0", L4, 1'b1, 1'b1);

        $display("[TB] %0d tests run, %0d failed", runs, fails);
        $finish;
    end
endmodule